// File: doc/BRIEF.md
# Type-C CC attach orientation controller

This block turns a sampled CC status byte from a Type-C port into the control state a port controller needs after a connection change. Each of the two CC pins carries a 2-bit code. A local-sink flag in the byte selects how those codes are read. The block decodes both pins into termination states (open, Ra, Rd, or one of three Rp current levels). It then classifies the pair as a detach, a source attach, a sink attach, an audio-accessory detach, or an invalid combination.

From that class the block sets the following registered outputs:

- a plug orientation bit and its inverse, the superspeed mux select;
- a CC termination control byte and a receive-detect enable byte;
- a message-header role byte;
- VCONN enable;
- source and sink VBUS request levels;
- an attached flag.

The block also issues a short burst of 8-bit port commands, one per clock: the disable commands first, then any enable or look-for-connection command. A status byte equal to the last one processed is ignored, so a host can forward every CC interrupt without filtering. When a detach is seen, dual-role toggling is re-armed. The toggle pattern depends on a try-host preference input.

The controller has two top-level states:

- **LISTEN** accepts strobes. The transition LISTEN→DRAIN is taken when an accepted byte yields commands.
- **DRAIN** lets the command sequencer run. The transition DRAIN→LISTEN is taken on the cycle of the last command.

The sequencer has its own two states, SEQ_IDLE and SEQ_ISSUE, with the transitions load→SEQ_ISSUE and last command→SEQ_IDLE.

Top module: `cc_attach_ctrl`

## Requirements
- R1: Pin codes sit at status bits [1:0] (CC1) and [3:2] (CC2), and bit 4 set means the local side is a sink. With bit 4 set, codes 1, 2 and 3 are Rp default, Rp 1.5 A and Rp 3.0 A. With bit 4 clear, code 1 is Ra and code 2 is Rd. Every other code is open.
- R2: A strobed byte equal to the last processed byte changes no output and issues no command.
- R3: Both pins open (detach) causes the following, with the role byte left unchanged:
  - receive detect 0x00;
  - source and sink VBUS requests low;
  - VCONN low;
  - orientation CC1 and attached low;
  - commands 0x66, 0x44, 0x99 in that order.
- R4: On detach, termination control becomes 0x4A when try-host is high and 0x45 when it is low (bit 6 is the dual-role bit).
- R5: Exactly one pin at Rd is a source attach. It sets orientation to the Rd pin, role byte 0x0B, receive detect 0x21, source request high, sink request low and attached high. It issues commands 0x44 then 0x77 and leaves termination control unchanged.
- R6: VCONN is set on a source attach only when the other pin shows Ra. Every other source attach, sink attach or detach clears it.
- R7: One pin at any Rp level with the other open is a sink attach. It sets:
  - orientation to the non-open pin;
  - termination control 0x0E for CC1 or 0x0B for CC2 (Rd code 2 on the active pin, open code 3 on the other, CC1 at [1:0]);
  - role byte 0x02 and VCONN low;
  - both VBUS requests low and attached high;
  - commands 0x66 then 0x44.
- R8: One pin at Ra with the other open (audio detach) changes no output and issues no command, but is recorded as the last processed byte.
- R9: Any other combination sets a sticky error flag, cleared only by reset, and changes nothing else, including the last processed byte.
- R10: Orientation output is 0 for CC1 and 1 for CC2; the superspeed select is always its inverse.
- R11: Commands appear as a one-cycle-per-code strobe on consecutive cycles, starting the cycle after the accepting edge.
- R12: Strobes arriving while commands are being issued are ignored.
- R13: After reset the outputs take these values, and the last processed byte is 0xFF:
  - orientation 0 and superspeed select 1;
  - termination control 0x00 and receive detect 0x00;
  - role byte 0x02;
  - VCONN, both VBUS requests, attached, error and command strobe all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cc_status | input | 8 | Sampled CC status byte |
| cc_valid | input | 1 | Strobe qualifying cc_status |
| prefer_host | input | 1 | Try-host preference for re-armed toggling |
| orient_cc2 | output | 1 | Plug orientation, 1 = CC2 |
| ss_sel | output | 1 | Superspeed mux select, high for CC1 |
| term_ctrl | output | 8 | CC termination control byte |
| rx_detect | output | 8 | Receive detect enables (bit 0 SOP, bit 5 hard reset) |
| role_hdr | output | 8 | Message-header role byte |
| vconn_en | output | 1 | VCONN enable |
| src_vbus_req | output | 1 | Source VBUS request |
| snk_vbus_req | output | 1 | Sink VBUS request |
| attached | output | 1 | Connection attached |
| err_sticky | output | 1 | Invalid combination seen since reset |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 8 | Command code |

## Verification
The assertions assume that cc_valid is a one-cycle pulse. They also assume any byte offered while commands drain may be dropped, so the ordering checks only see bursts that started in LISTEN. The stimulus holds each strobe for exactly one cycle and waits five cycles before the next. Only the directed drain case deliberately strobes during a burst, to show it is ignored. The random bytes cover every pin-code pair under both sink-flag values and both preferences, so invalid and audio combinations are reached as well as attaches.

// File: rtl/cc_attach_pkg.sv
package cc_attach_pkg;

    typedef enum logic [2:0] {
        TERM_OPEN,
        TERM_RA,
        TERM_RD,
        TERM_RP_DEF,
        TERM_RP_1A5,
        TERM_RP_3A0
    } term_e;

    typedef enum logic [2:0] {
        CLS_DETACH,
        CLS_SOURCE,
        CLS_SINK,
        CLS_AUDIO,
        CLS_BAD
    } class_e;

    localparam logic [7:0] CMD_SRC_OFF = 8'h66;
    localparam logic [7:0] CMD_SNK_OFF = 8'h44;
    localparam logic [7:0] CMD_SRC_ON  = 8'h77;
    localparam logic [7:0] CMD_LOOK    = 8'h99;

    localparam logic [1:0] TC_RD   = 2'd2;
    localparam logic [1:0] TC_OPEN = 2'd3;

    function automatic term_e decode_pin(input logic [1:0] code, input logic as_sink);
        term_e t;
        t = TERM_OPEN;
        if (as_sink) begin
            unique case (code)
                2'd1:    t = TERM_RP_DEF;
                2'd2:    t = TERM_RP_1A5;
                2'd3:    t = TERM_RP_3A0;
                default: t = TERM_OPEN;
            endcase
        end else begin
            unique case (code)
                2'd1:    t = TERM_RA;
                2'd2:    t = TERM_RD;
                default: t = TERM_OPEN;
            endcase
        end
        return t;
    endfunction

    function automatic logic is_rp(input term_e t);
        return (t == TERM_RP_DEF) || (t == TERM_RP_1A5) || (t == TERM_RP_3A0);
    endfunction

endpackage

// File: rtl/cc_classify.sv
module cc_classify
    import cc_attach_pkg::*;
(
    input  logic [4:0] status_lo,
    output class_e     cls,
    output logic       flip,
    output logic       other_ra
);

    term_e t1;
    term_e t2;

    assign t1 = decode_pin(status_lo[1:0], status_lo[4]);
    assign t2 = decode_pin(status_lo[3:2], status_lo[4]);

    always_comb begin
        cls      = CLS_BAD;
        flip     = 1'b0;
        other_ra = 1'b0;
        if (t1 == TERM_OPEN && t2 == TERM_OPEN) begin
            cls = CLS_DETACH;
        end else if ((t1 == TERM_RD) != (t2 == TERM_RD)) begin
            cls      = CLS_SOURCE;
            flip     = (t1 != TERM_RD);
            other_ra = (t1 == TERM_RD) ? (t2 == TERM_RA) : (t1 == TERM_RA);
        end else if (is_rp(t1) && t2 == TERM_OPEN) begin
            cls = CLS_SINK;
        end else if (is_rp(t2) && t1 == TERM_OPEN) begin
            cls  = CLS_SINK;
            flip = 1'b1;
        end else if ((t1 == TERM_RA && t2 == TERM_OPEN) ||
                     (t2 == TERM_RA && t1 == TERM_OPEN)) begin
            cls = CLS_AUDIO;
        end
    end

endmodule

// File: rtl/cc_cmd_seq.sv
module cc_cmd_seq
    import cc_attach_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int DEPTH  = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [CNT_W-1:0]             load_cnt,
    input  logic [DEPTH-1:0][CODE_W-1:0] load_codes,
    output logic                         cmd_valid,
    output logic [CODE_W-1:0]            cmd_code,
    output logic                         last
);

    typedef enum logic {SEQ_IDLE, SEQ_ISSUE} seq_e;

    seq_e                         st_q;
    logic [CNT_W-1:0]             idx_q;
    logic [CNT_W-1:0]             cnt_q;
    logic [DEPTH-1:0][CODE_W-1:0] codes_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= SEQ_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            codes_q <= '0;
        end else if (load) begin
            codes_q <= load_codes;
            cnt_q   <= load_cnt;
            idx_q   <= '0;
            st_q    <= (load_cnt != '0) ? SEQ_ISSUE : SEQ_IDLE;
        end else begin
            unique case (st_q)
                SEQ_IDLE:  st_q <= SEQ_IDLE;
                SEQ_ISSUE: begin
                    if (last) st_q <= SEQ_IDLE;
                    else      idx_q <= idx_q + CNT_W'(1);
                end
            endcase
        end
    end

    assign cmd_valid = (st_q == SEQ_ISSUE);
    assign cmd_code  = cmd_valid ? codes_q[idx_q] : '0;
    assign last      = cmd_valid && (idx_q == cnt_q - CNT_W'(1));

    // R11: look-for-connection always follows the sink-off command directly
    assert_look_after_snk_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CODE_W'(CMD_LOOK)) |->
            ($past(cmd_valid) && $past(cmd_code) == CODE_W'(CMD_SNK_OFF)));

    // R11: source-on always follows the sink-off command directly
    assert_src_on_after_snk_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CODE_W'(CMD_SRC_ON)) |->
            ($past(cmd_valid) && $past(cmd_code) == CODE_W'(CMD_SNK_OFF)));

endmodule

// File: rtl/cc_attach_ctrl.sv
module cc_attach_ctrl
    import cc_attach_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int CMD_DEPTH = 3,
    localparam int CNT_W    = $clog2(CMD_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cc_status,
    input  logic              cc_valid,
    input  logic              prefer_host,
    output logic              orient_cc2,
    output logic              ss_sel,
    output logic [BYTE_W-1:0] term_ctrl,
    output logic [BYTE_W-1:0] rx_detect,
    output logic [BYTE_W-1:0] role_hdr,
    output logic              vconn_en,
    output logic              src_vbus_req,
    output logic              snk_vbus_req,
    output logic              attached,
    output logic              err_sticky,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_code
);

    // CMD_DEPTH must be at least 3: a detach issues three commands.
    typedef enum logic {ST_LISTEN, ST_DRAIN} top_e;

    localparam logic [BYTE_W-1:0] ROLE_BASE  = BYTE_W'(8'h02);
    localparam logic [BYTE_W-1:0] ROLE_SRC   = BYTE_W'(8'h0B);
    localparam logic [BYTE_W-1:0] RX_ON      = BYTE_W'(8'h21);
    localparam logic [BYTE_W-1:0] TOG_HOST   = BYTE_W'(8'h4A);
    localparam logic [BYTE_W-1:0] TOG_DEV    = BYTE_W'(8'h45);
    localparam logic [BYTE_W-1:0] SNK_TERM_1 = BYTE_W'({4'h0, TC_OPEN, TC_RD});
    localparam logic [BYTE_W-1:0] SNK_TERM_2 = BYTE_W'({4'h0, TC_RD, TC_OPEN});

    top_e        st_q;
    top_e        st_d;
    logic [BYTE_W-1:0] last_q;
    class_e      cls;
    logic        flip;
    logic        other_ra;
    logic        accept;
    logic        act;
    logic        seq_last;
    logic [CNT_W-1:0]                  load_cnt;
    logic [CMD_DEPTH-1:0][BYTE_W-1:0]  load_codes;

    cc_classify u_classify (
        .status_lo (cc_status[4:0]),
        .cls       (cls),
        .flip      (flip),
        .other_ra  (other_ra)
    );

    assign accept = (st_q == ST_LISTEN) && cc_valid && (cc_status != last_q);
    assign act    = accept && (cls == CLS_DETACH || cls == CLS_SOURCE || cls == CLS_SINK);

    always_comb begin
        load_codes = '0;
        load_cnt   = '0;
        unique case (cls)
            CLS_DETACH: begin
                load_codes[0] = BYTE_W'(CMD_SRC_OFF);
                load_codes[1] = BYTE_W'(CMD_SNK_OFF);
                load_codes[2] = BYTE_W'(CMD_LOOK);
                load_cnt      = CNT_W'(3);
            end
            CLS_SOURCE: begin
                load_codes[0] = BYTE_W'(CMD_SNK_OFF);
                load_codes[1] = BYTE_W'(CMD_SRC_ON);
                load_cnt      = CNT_W'(2);
            end
            CLS_SINK: begin
                load_codes[0] = BYTE_W'(CMD_SRC_OFF);
                load_codes[1] = BYTE_W'(CMD_SNK_OFF);
                load_cnt      = CNT_W'(2);
            end
            CLS_AUDIO, CLS_BAD: load_cnt = '0;
            default:            load_cnt = '0;
        endcase
    end

    cc_cmd_seq #(.CODE_W(BYTE_W), .DEPTH(CMD_DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (act),
        .load_cnt   (load_cnt),
        .load_codes (load_codes),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .last       (seq_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LISTEN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LISTEN: if (act)      st_d = ST_DRAIN;
            ST_DRAIN:  if (seq_last) st_d = ST_LISTEN;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q       <= '1;
            orient_cc2   <= 1'b0;
            ss_sel       <= 1'b1;
            term_ctrl    <= '0;
            rx_detect    <= '0;
            role_hdr     <= ROLE_BASE;
            vconn_en     <= 1'b0;
            src_vbus_req <= 1'b0;
            snk_vbus_req <= 1'b0;
            attached     <= 1'b0;
            err_sticky   <= 1'b0;
        end else if (accept) begin
            unique case (cls)
                CLS_DETACH: begin
                    last_q       <= cc_status;
                    rx_detect    <= '0;
                    src_vbus_req <= 1'b0;
                    snk_vbus_req <= 1'b0;
                    vconn_en     <= 1'b0;
                    orient_cc2   <= 1'b0;
                    ss_sel       <= 1'b1;
                    attached     <= 1'b0;
                    term_ctrl    <= prefer_host ? TOG_HOST : TOG_DEV;
                end
                CLS_SOURCE: begin
                    last_q       <= cc_status;
                    orient_cc2   <= flip;
                    ss_sel       <= ~flip;
                    role_hdr     <= ROLE_SRC;
                    rx_detect    <= RX_ON;
                    vconn_en     <= other_ra;
                    src_vbus_req <= 1'b1;
                    snk_vbus_req <= 1'b0;
                    attached     <= 1'b1;
                end
                CLS_SINK: begin
                    last_q       <= cc_status;
                    orient_cc2   <= flip;
                    ss_sel       <= ~flip;
                    term_ctrl    <= flip ? SNK_TERM_2 : SNK_TERM_1;
                    role_hdr     <= ROLE_BASE;
                    vconn_en     <= 1'b0;
                    src_vbus_req <= 1'b0;
                    snk_vbus_req <= 1'b0;
                    attached     <= 1'b1;
                end
                CLS_AUDIO: last_q     <= cc_status;
                CLS_BAD:   err_sticky <= 1'b1;
                default:   err_sticky <= 1'b1;
            endcase
        end
    end

    // R10: superspeed select is the inverse of the orientation bit
    assert_ss_inverse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ss_sel != orient_cc2);

    // R2: a repeated byte leaves every output as it was and issues nothing
    assert_repeat_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LISTEN && cc_valid && cc_status == last_q) |=>
            ($stable(term_ctrl) && $stable(role_hdr) && $stable(attached) &&
             $stable(orient_cc2) && $stable(vconn_en) && !cmd_valid));

    // R6: VCONN is only ever on together with a source VBUS request
    assert_vconn_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vconn_en |-> src_vbus_req);

    // R9: the error flag never clears once set
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R3: losing the attachment drops power and orientation at the same time
    assert_detach_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(attached) |-> (!vconn_en && !src_vbus_req && !snk_vbus_req && !orient_cc2));

    // R12: no new burst loads while the previous burst drains
    assert_no_reload_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !seq_last) |=> cmd_valid);

endmodule

// File: tb/sim_cc_attach_ctrl.sv
module sim_cc_attach_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cc_status = 8'h00;
    logic       cc_valid = 1'b0;
    logic       prefer_host = 1'b1;
    logic       orient_cc2, ss_sel, vconn_en, src_vbus_req, snk_vbus_req;
    logic       attached, err_sticky, cmd_valid;
    logic [7:0] term_ctrl, rx_detect, role_hdr, cmd_code;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cc_attach_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cc_status(cc_status), .cc_valid(cc_valid),
        .prefer_host(prefer_host), .orient_cc2(orient_cc2), .ss_sel(ss_sel),
        .term_ctrl(term_ctrl), .rx_detect(rx_detect), .role_hdr(role_hdr),
        .vconn_en(vconn_en), .src_vbus_req(src_vbus_req), .snk_vbus_req(snk_vbus_req),
        .attached(attached), .err_sticky(err_sticky), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code)
    );

    // model state
    bit       m_or, m_vc, m_src, m_snk, m_att, m_err;
    bit [7:0] m_term, m_rx, m_role, m_last;
    bit [7:0] e_cmd [0:7];
    int       e_n;
    bit [7:0] log_cmd [0:7];
    int       log_n = 0;

    always @(negedge clk) begin
        if (cmd_valid) begin
            if (log_n < 8) log_cmd[log_n] = cmd_code;
            log_n++;
        end
    end

    // 0 open, 1 Ra, 2 Rd, 3..5 Rp levels
    function automatic int bt(bit [1:0] c, bit s);
        if (s) return (c == 2'd0) ? 0 : int'(c) + 2;
        if (c == 2'd1) return 1;
        if (c == 2'd2) return 2;
        return 0;
    endfunction

    task automatic model(input bit [7:0] b);
        int a, c;
        e_n = 0;
        if (b == m_last) return;
        a = bt(b[1:0], b[4]);
        c = bt(b[3:2], b[4]);
        if (a == 0 && c == 0) begin
            m_last = b; m_rx = 0; m_src = 0; m_snk = 0; m_vc = 0; m_or = 0; m_att = 0;
            m_term = prefer_host ? 8'h4A : 8'h45;
            e_cmd[0] = 8'h66; e_cmd[1] = 8'h44; e_cmd[2] = 8'h99; e_n = 3;
        end else if ((a == 2) != (c == 2)) begin
            m_last = b; m_or = (a != 2); m_role = 8'h0B; m_rx = 8'h21;
            m_vc = (a == 2) ? (c == 1) : (a == 1);
            m_src = 1; m_snk = 0; m_att = 1;
            e_cmd[0] = 8'h44; e_cmd[1] = 8'h77; e_n = 2;
        end else if ((a >= 3 && c == 0) || (c >= 3 && a == 0)) begin
            m_last = b; m_or = (a == 0); m_term = (a == 0) ? 8'h0B : 8'h0E;
            m_role = 8'h02; m_vc = 0; m_src = 0; m_snk = 0; m_att = 1;
            e_cmd[0] = 8'h66; e_cmd[1] = 8'h44; e_n = 2;
        end else if ((a == 1 && c == 0) || (a == 0 && c == 1)) begin
            m_last = b;
        end else begin
            m_err = 1;
        end
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "orient", orient_cc2, m_or);
        chk("R10", "ss_sel", ss_sel, !m_or);
        chk(tag, "term_ctrl", term_ctrl, m_term);
        chk(tag, "rx_detect", rx_detect, m_rx);
        chk(tag, "role_hdr", role_hdr, m_role);
        chk(tag, "vconn", vconn_en, m_vc);
        chk(tag, "src_req", src_vbus_req, m_src);
        chk(tag, "snk_req", snk_vbus_req, m_snk);
        chk(tag, "attached", attached, m_att);
        chk(tag, "err", err_sticky, m_err);
        chk("R11", "cmd_count", log_n, e_n);
        for (int i = 0; i < e_n && i < log_n && i < 8; i++)
            chk("R11", "cmd_code", log_cmd[i], e_cmd[i]);
    endtask

    task automatic apply(input bit [7:0] b, input string tag);
        model(b);
        log_n = 0;
        @(negedge clk); cc_status = b; cc_valid = 1'b1;
        @(negedge clk); cc_valid = 1'b0;
        repeat (5) @(negedge clk);
        compare(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        m_or = 0; m_vc = 0; m_src = 0; m_snk = 0; m_att = 0; m_err = 0;
        m_term = 0; m_rx = 0; m_role = 8'h02; m_last = 8'hFF; e_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        compare("R13");

        prefer_host = 1'b1;
        apply(8'h00, "R3");          // detach, host preferred: R4 0x4A
        chk("R4", "term_host", term_ctrl, 8'h4A);
        apply(8'h00, "R2");          // repeated byte: nothing
        apply(8'h06, "R5");          // CC1 Rd, CC2 Ra: source with VCONN (R6)
        chk("R6", "vconn_ra", vconn_en, 1);
        apply(8'h08, "R10");         // CC2 Rd, CC1 open: flipped source, no VCONN
        chk("R6", "vconn_no_ra", vconn_en, 0);
        prefer_host = 1'b0;
        apply(8'h03, "R4");          // code 3 without sink flag is open: detach, 0x45
        apply(8'h12, "R7");          // sink flag, CC1 Rp1.5: sink on CC1
        apply(8'h02, "R1");          // same code without sink flag is Rd: source
        apply(8'h1C, "R7");          // sink on CC2: term 0x0B
        apply(8'h01, "R8");          // Ra + open: audio detach, no change
        apply(8'h05, "R9");          // Ra + Ra: invalid, sticky error
        apply(8'h0A, "R9");          // Rd + Rd: invalid, still sticky

        // R12: strobe during a command burst is dropped
        prefer_host = 1'b1;
        model(8'h0F);
        log_n = 0;
        @(negedge clk); cc_status = 8'h0F; cc_valid = 1'b1;
        @(negedge clk); cc_status = 8'h06; cc_valid = 1'b1;
        @(negedge clk); cc_valid = 1'b0;
        repeat (5) @(negedge clk);
        compare("R12");

        for (int k = 0; k < 400; k++) begin
            bit [7:0] b;
            b = 8'($urandom);
            prefer_host = 1'($urandom);
            apply(b, "R1");
        end

        done = 1;
        finish_run();
    end

endmodule